// File: doc/BRIEF.md
# B-Tree Node Key Search

This block performs the lookup step inside a single B-tree node, with no clock. A node holds a fixed number of slots. Each slot has a key, a data word and a child link, and the node has one extra top link. Keys are stored in ascending order from slot 0 upward.

When enable is high, the search key is compared with every stored key at once. Two one-hot masks come out of the comparison. The equality mask marks the slot whose key matches. The first-greater mask marks the lowest slot whose key is strictly larger than the search key. Each mask drives an AND-OR selector: each word is gated by its mask bit and the gated words are ORed together. One selector returns the matching data word and the other returns the child link to follow. If no stored key is larger than the search key, the top link is routed to the link output instead.

A tree walker places a node's contents on the inputs, asserts enable and reads the result in the same cycle. Leaves supply data. Interior nodes are used only for their links.

Top module: `btree_node_search`

## Requirements
- R1: While `en_i` is low, `found_o`, `data_o` and `next_o` are all zero, whatever the other inputs are.
- R2: While `en_i` is high, `found_o` is 1 exactly when some stored key equals `find_i`.
- R3: On a hit, `data_o` equals the data word of the matching slot. On a miss, `data_o` is zero.
- R4: While `en_i` is high, `next_o` equals the link of the lowest slot whose key is strictly greater than `find_i`. After a hit, this is the slot just above the match.
- R5: While `en_i` is high and no stored key is greater than `find_i`, `next_o` equals `top_i`.
- R6: When `find_i` is smaller than every stored key, `next_o` equals the link of slot 0.
- R7: The masks built internally are one-hot or all-zero. Slot i occupies bits [i*W +: W] of each packed array port, where W is that field's width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_i | input | 1 | Search enable |
| find_i | input | KEY_W | Search key |
| keys_i | input | SLOTS*KEY_W | Stored keys, ascending, slot 0 in the low bits |
| data_i | input | SLOTS*DATA_W | Data word of each slot |
| link_i | input | SLOTS*LINK_W | Child link of each slot |
| top_i | input | LINK_W | Link used when no key is greater |
| found_o | output | 1 | Equal key present |
| data_o | output | DATA_W | Data of the matching slot, else zero |
| next_o | output | LINK_W | Child link to follow |

## Verification
Directed cases cover the following patterns:
- A hit on each slot, which checks that the data and link selectors pick the matching slot and the slot above it.
- A miss between two keys, which separates the equality path from the first-greater path.
- A miss below the smallest key, which checks that slot 0 is chosen.
- A miss above the largest key, which checks that the top link is chosen.
- Searches with enable low and busy inputs, which show that the outputs stay zero.

Random sorted key sets with random search keys then exercise both the equal and the greater comparisons at their edges.

// File: rtl/btree_search_pkg.sv
package btree_search_pkg;
    typedef enum logic [1:0] {
        ROUTE_IDLE = 2'd0,
        ROUTE_SLOT = 2'd1,
        ROUTE_TOP  = 2'd2
    } route_e;
endpackage

// File: rtl/node_key_compare.sv
module node_key_compare #(
    parameter int SLOTS = 3,
    parameter int KEY_W = 3
) (
    input  logic                   en_i,
    input  logic [KEY_W-1:0]       find_i,
    input  logic [SLOTS*KEY_W-1:0] keys_i,
    output logic [SLOTS-1:0]       eq_mask_o,
    output logic [SLOTS-1:0]       more_mask_o
);
    logic [SLOTS-1:0] gt;

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_cmp
            assign eq_mask_o[g] = en_i && (keys_i[g*KEY_W +: KEY_W] == find_i);
            assign gt[g]        = en_i && (keys_i[g*KEY_W +: KEY_W] >  find_i);
            if (g == 0) begin : g_first
                assign more_mask_o[g] = gt[g];
            end else begin : g_rest
                assign more_mask_o[g] = gt[g] & ~gt[g-1];
            end
        end
    endgenerate

    always_comb begin
        // R7
        eq_onehot_chk: assert ($onehot0(eq_mask_o)) else $error("equality mask not one-hot");
        // R7
        more_onehot_chk: assert ($onehot0(more_mask_o)) else $error("greater mask not one-hot");
    end
endmodule

// File: rtl/mask_select.sv
module mask_select #(
    parameter int SLOTS = 3,
    parameter int W     = 3
) (
    input  logic [SLOTS-1:0]   mask_i,
    input  logic [SLOTS*W-1:0] words_i,
    output logic [W-1:0]       word_o
);
    always_comb begin
        word_o = '0;
        for (int i = 0; i < SLOTS; i++) begin
            word_o = word_o | ({W{mask_i[i]}} & words_i[i*W +: W]);
        end
    end
endmodule

// File: rtl/btree_node_search.sv
module btree_node_search
    import btree_search_pkg::*;
#(
    parameter int SLOTS  = 3,
    parameter int KEY_W  = 3,
    parameter int DATA_W = 3,
    parameter int LINK_W = 3
) (
    input  logic                    en_i,
    input  logic [KEY_W-1:0]        find_i,
    input  logic [SLOTS*KEY_W-1:0]  keys_i,
    input  logic [SLOTS*DATA_W-1:0] data_i,
    input  logic [SLOTS*LINK_W-1:0] link_i,
    input  logic [LINK_W-1:0]       top_i,
    output logic                    found_o,
    output logic [DATA_W-1:0]       data_o,
    output logic [LINK_W-1:0]       next_o
);
    logic [SLOTS-1:0]  eq_mask;
    logic [SLOTS-1:0]  more_mask;
    logic [LINK_W-1:0] slot_link;
    route_e            route;

    node_key_compare #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_cmp (
        .en_i       (en_i),
        .find_i     (find_i),
        .keys_i     (keys_i),
        .eq_mask_o  (eq_mask),
        .more_mask_o(more_mask)
    );

    mask_select #(.SLOTS(SLOTS), .W(DATA_W)) u_data_sel (
        .mask_i (eq_mask),
        .words_i(data_i),
        .word_o (data_o)
    );

    mask_select #(.SLOTS(SLOTS), .W(LINK_W)) u_link_sel (
        .mask_i (more_mask),
        .words_i(link_i),
        .word_o (slot_link)
    );

    assign found_o = |eq_mask;

    always_comb begin
        if (!en_i)            route = ROUTE_IDLE;
        else if (|more_mask)  route = ROUTE_SLOT;
        else                  route = ROUTE_TOP;
    end

    always_comb begin
        unique case (route)
            ROUTE_SLOT: next_o = slot_link;
            ROUTE_TOP:  next_o = top_i;
            default:    next_o = '0;
        endcase
    end

    always_comb begin
        // R1
        idle_zero_chk: assert (en_i || (!found_o && data_o == '0 && next_o == '0))
            else $error("outputs not zero while disabled");
        // R3
        miss_data_chk: assert (found_o || data_o == '0)
            else $error("data driven on a miss");
        // R5
        top_route_chk: assert (!(en_i && more_mask == '0) || next_o == top_i)
            else $error("top link not selected");
    end
endmodule

// File: tb/sim_btree_node_search.sv
module sim_btree_node_search;
    localparam int SLOTS = 3, KW = 3, DW = 3, LW = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                en;
    logic [KW-1:0]       find;
    logic [SLOTS*KW-1:0] keys;
    logic [SLOTS*DW-1:0] data;
    logic [SLOTS*LW-1:0] link;
    logic [LW-1:0]       top;
    logic                found;
    logic [DW-1:0]       dout;
    logic [LW-1:0]       nxt;

    int checks = 0, errors = 0;
    bit done = 0;

    btree_node_search #(.SLOTS(SLOTS), .KEY_W(KW), .DATA_W(DW), .LINK_W(LW)) u0 (
        .en_i(en), .find_i(find), .keys_i(keys), .data_i(data),
        .link_i(link), .top_i(top), .found_o(found), .data_o(dout), .next_o(nxt)
    );

    function automatic logic ref_found();
        if (!en) return 1'b0;
        for (int i = 0; i < SLOTS; i++) if (keys[i*KW +: KW] == find) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [DW-1:0] ref_data();
        if (!en) return '0;
        for (int i = 0; i < SLOTS; i++) if (keys[i*KW +: KW] == find) return data[i*DW +: DW];
        return '0;
    endfunction

    function automatic logic [LW-1:0] ref_next();
        if (!en) return '0;
        for (int i = 0; i < SLOTS; i++) if (keys[i*KW +: KW] > find) return link[i*LW +: LW];
        return top;
    endfunction

    task automatic check(input string req);
        @(negedge clk);
        checks++;
        if (found !== ref_found() || dout !== ref_data() || nxt !== ref_next()) begin
            errors++;
            $display("FAIL %s: find=%0d en=%0b got found=%0b data=%0d next=%0d exp found=%0b data=%0d next=%0d",
                     req, find, en, found, dout, nxt, ref_found(), ref_data(), ref_next());
        end
    endtask

    task automatic apply(input logic e, input logic [KW-1:0] f, input string req);
        @(posedge clk);
        en = e; find = f;
        check(req);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        en = 0; find = 0;
        keys = {3'd6, 3'd4, 3'd2};
        data = {3'd5, 3'd3, 3'd1};
        link = {3'd5, 3'd3, 3'd1};
        top  = 3'd7;
        check("R1 reset");
        apply(1, 3'd4, "R3 R4 example hit on middle slot");
        apply(1, 3'd2, "R2 R4 hit slot 0");
        apply(1, 3'd6, "R5 hit top slot routes to top");
        apply(1, 3'd3, "R2 miss between keys");
        apply(1, 3'd5, "R4 miss between upper keys");
        apply(1, 3'd1, "R6 miss below smallest");
        apply(1, 3'd0, "R6 zero key");
        apply(1, 3'd7, "R5 miss above largest");
        apply(0, 3'd4, "R1 disabled on a hit key");
        apply(0, 3'd7, "R1 disabled on top route");
        keys = {3'd7, 3'd1, 3'd0};
        apply(1, 3'd0, "R7 slot 0 key zero hit");
        apply(1, 3'd7, "R5 max key hit selects top");
        for (int n = 0; n < 400; n++) begin
            logic [KW-1:0] a, b, c;
            do begin
                a = KW'($urandom); b = KW'($urandom); c = KW'($urandom);
            end while (!(a < b && b < c));
            keys = {c, b, a};
            data = SLOTS*DW'($urandom);
            link = SLOTS*LW'($urandom);
            top  = LW'($urandom);
            apply(($urandom % 8) != 0, KW'($urandom), "R2 R3 R4 random");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule